// File: doc/BRIEF.md
# Eviction-Read-Write Ordering Hazard Detector

This block sits in a persistent-memory controller that receives store data on a separate direct-write path from the cores. Eviction notices from the last-level cache carry no data, so their data is discarded. There is a short window between an eviction and the arrival of the matching direct write. In that window a read that misses the caches can fetch a stale line from memory. The detector watches three valid/address streams: eviction notices, memory reads and direct writes. It reports when a read and then a direct write land on a line that was recently evicted.

A small table holds recently evicted line addresses. Each slot runs its own tracker, which moves from evicted to read-seen to pending. Each slot also has a down-counter that limits its life to the worst-case network latency between the store buffers and the controller. A completed pattern produces a one-cycle interrupt pulse that carries the line address, and the slot is released in the same cycle.

Top module: `evict_hazard_watch`

## Requirements
- R1: Reset empties the table and holds `irq_valid` low. A pattern started before reset cannot complete after it.
- R2: Three events on the same line complete the pattern, in this order: an eviction, then a read, then a direct write. `irq_valid` rises in the cycle after the edge that samples the write, and `irq_addr` equals that line address.
- R3: A direct write to a line that has been evicted but not yet read raises no interrupt. The slot keeps waiting, so a later read followed by a write still raises it.
- R4: Reads and writes to a line that is not in the table raise no interrupt.
- R5: An eviction sampled at edge E0 keeps its slot open through edge E(LIFETIME). A read counts only when it is sampled at or before edge E(LIFETIME-1). A completing write counts only when it is sampled at or before edge E(LIFETIME). Events sampled later have no effect.
- R6: An eviction of a line that is already tracked returns its slot to the evicted state and reloads the full lifetime. Any read seen earlier on that line is forgotten.
- R7: An eviction that arrives when every slot is occupied replaces the tracked line with the least remaining lifetime. On a tie, the lowest slot index is replaced.
- R8: The interrupt lasts one cycle and frees its slot. A further write to the same line raises nothing.
- R9: A read and a write sampled together on a line in the evicted state count as the read alone. The write is not flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Eviction notice present |
| ev_addr | input | ADDR_W | Line address of the eviction |
| rd_valid | input | 1 | Memory read present |
| rd_addr | input | ADDR_W | Line address of the read |
| wr_valid | input | 1 | Direct write present |
| wr_addr | input | ADDR_W | Line address of the direct write |
| irq_valid | output | 1 | One-cycle violation pulse |
| irq_addr | output | ADDR_W | Line address of the violation |

## Verification
A slot stuck in the wrong tracker state shows up as a missing or spurious `irq_valid`, visible one cycle after the write that should or should not complete the pattern. A timer that is off by one moves the last effective read or write by one edge. The bench therefore probes both sides of that boundary. A wrong victim choice only becomes visible later, when reads and writes aimed at the displaced and surviving lines do or do not produce an interrupt.

// File: rtl/ehw_pkg.sv
package ehw_pkg;
   typedef enum logic [1:0] {
      SLOT_FREE    = 2'd0,
      SLOT_EVICTED = 2'd1,
      SLOT_READ    = 2'd2,
      SLOT_PENDING = 2'd3
   } slot_state_e;
endpackage

// File: rtl/ehw_slot.sv
module ehw_slot
   import ehw_pkg::*;
#(
   parameter int ADDR_W   = 26,
   parameter int LIFETIME = 64,
   localparam int CNT_W   = $clog2(LIFETIME + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] load_addr_i,
   input  logic              clear_i,
   input  logic              ev_valid_i,
   input  logic [ADDR_W-1:0] ev_addr_i,
   input  logic              rd_valid_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   input  logic              wr_valid_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [CNT_W-1:0]  timer_o,
   output logic              live_o,
   output logic              pend_o,
   output logic              ev_hit_o
);
   slot_state_e       state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  timer_q;
   logic              last_tick;
   logic              rd_hit;
   logic              wr_hit;

   assign live_o    = (state_q == SLOT_EVICTED) || (state_q == SLOT_READ);
   assign pend_o    = (state_q == SLOT_PENDING);
   assign addr_o    = addr_q;
   assign timer_o   = timer_q;
   assign ev_hit_o  = live_o && ev_valid_i && (ev_addr_i == addr_q);
   assign rd_hit    = rd_valid_i && (rd_addr_i == addr_q);
   assign wr_hit    = wr_valid_i && (wr_addr_i == addr_q);
   assign last_tick = (timer_q == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SLOT_FREE;
         addr_q  <= '0;
         timer_q <= '0;
      end else if (load_i) begin
         state_q <= SLOT_EVICTED;
         addr_q  <= load_addr_i;
         timer_q <= CNT_W'(LIFETIME);
      end else if (clear_i) begin
         state_q <= SLOT_FREE;
         timer_q <= '0;
      end else begin
         unique case (state_q)
            SLOT_EVICTED: begin
               if (last_tick) begin
                  state_q <= SLOT_FREE;
                  timer_q <= '0;
               end else begin
                  timer_q <= timer_q - CNT_W'(1);
                  if (rd_hit) state_q <= SLOT_READ;
               end
            end
            SLOT_READ: begin
               if (wr_hit) begin
                  state_q <= SLOT_PENDING;
               end else if (last_tick) begin
                  state_q <= SLOT_FREE;
                  timer_q <= '0;
               end else begin
                  timer_q <= timer_q - CNT_W'(1);
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/ehw_alloc.sv
module ehw_alloc #(
   parameter int ENTRIES = 4,
   parameter int CNT_W   = 7
) (
   input  logic                            ev_valid_i,
   input  logic [ENTRIES-1:0]              live_i,
   input  logic [ENTRIES-1:0]              pend_i,
   input  logic [ENTRIES-1:0]              ev_hit_i,
   input  logic [ENTRIES-1:0][CNT_W-1:0]   timer_i,
   output logic [ENTRIES-1:0]              load_o
);
   logic [ENTRIES-1:0] free_slot;
   logic [ENTRIES-1:0] first_free;
   logic [ENTRIES-1:0] victim;
   logic               got_free;
   logic               got_victim;
   logic [CNT_W-1:0]   best;

   assign free_slot = ~(live_i | pend_i);

   always_comb begin
      first_free = '0;
      got_free   = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (free_slot[i] && !got_free) begin
            first_free[i] = 1'b1;
            got_free      = 1'b1;
         end
      end
   end

   always_comb begin
      victim     = '0;
      got_victim = 1'b0;
      best       = '1;
      for (int i = 0; i < ENTRIES; i++) begin
         if (live_i[i] && (!got_victim || timer_i[i] < best)) begin
            victim     = '0;
            victim[i]  = 1'b1;
            best       = timer_i[i];
            got_victim = 1'b1;
         end
      end
   end

   always_comb begin
      load_o = '0;
      if (ev_valid_i) begin
         if (|ev_hit_i)     load_o = ev_hit_i;
         else if (got_free) load_o = first_free;
         else               load_o = victim;
      end
   end
endmodule

// File: rtl/ehw_report.sv
module ehw_report #(
   parameter int ADDR_W  = 26,
   parameter int ENTRIES = 4
) (
   input  logic [ENTRIES-1:0]             pend_i,
   input  logic [ENTRIES-1:0][ADDR_W-1:0] addr_i,
   output logic [ENTRIES-1:0]             clear_o,
   output logic                           irq_valid_o,
   output logic [ADDR_W-1:0]              irq_addr_o
);
   logic taken;

   always_comb begin
      clear_o    = '0;
      irq_addr_o = '0;
      taken      = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (pend_i[i] && !taken) begin
            clear_o[i] = 1'b1;
            irq_addr_o = addr_i[i];
            taken      = 1'b1;
         end
      end
   end

   assign irq_valid_o = |pend_i;
endmodule

// File: rtl/evict_hazard_watch.sv
module evict_hazard_watch #(
   parameter int ADDR_W   = 26,
   parameter int ENTRIES  = 4,
   parameter int LIFETIME = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_valid,
   input  logic [ADDR_W-1:0] ev_addr,
   input  logic              rd_valid,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   output logic              irq_valid,
   output logic [ADDR_W-1:0] irq_addr
);
   localparam int CNT_W = $clog2(LIFETIME + 1);

   if (ADDR_W < 1)    begin : g_bad_addr  $error("ADDR_W must be positive");   end
   if (ENTRIES < 2)   begin : g_bad_depth $error("ENTRIES must be at least 2"); end
   if (LIFETIME < 2)  begin : g_bad_life  $error("LIFETIME must be at least 2"); end

   logic [ENTRIES-1:0]             live_vec;
   logic [ENTRIES-1:0]             pend_vec;
   logic [ENTRIES-1:0]             hit_vec;
   logic [ENTRIES-1:0]             load_vec;
   logic [ENTRIES-1:0]             clear_vec;
   logic [ENTRIES-1:0][CNT_W-1:0]  timer_vec;
   logic [ENTRIES-1:0][ADDR_W-1:0] addr_vec;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      ehw_slot #(.ADDR_W(ADDR_W), .LIFETIME(LIFETIME)) u_slot (
         .clk         (clk),
         .rst_n       (rst_n),
         .load_i      (load_vec[g]),
         .load_addr_i (ev_addr),
         .clear_i     (clear_vec[g]),
         .ev_valid_i  (ev_valid),
         .ev_addr_i   (ev_addr),
         .rd_valid_i  (rd_valid),
         .rd_addr_i   (rd_addr),
         .wr_valid_i  (wr_valid),
         .wr_addr_i   (wr_addr),
         .addr_o      (addr_vec[g]),
         .timer_o     (timer_vec[g]),
         .live_o      (live_vec[g]),
         .pend_o      (pend_vec[g]),
         .ev_hit_o    (hit_vec[g])
      );
   end

   ehw_alloc #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_alloc (
      .ev_valid_i (ev_valid),
      .live_i     (live_vec),
      .pend_i     (pend_vec),
      .ev_hit_i   (hit_vec),
      .timer_i    (timer_vec),
      .load_o     (load_vec)
   );

   ehw_report #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_report (
      .pend_i      (pend_vec),
      .addr_i      (addr_vec),
      .clear_o     (clear_vec),
      .irq_valid_o (irq_valid),
      .irq_addr_o  (irq_addr)
   );
endmodule

// File: rtl/evict_hazard_watch_chk.sv
module evict_hazard_watch_chk #(
   parameter int ADDR_W  = 26,
   parameter int ENTRIES = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_valid,
   input logic [ADDR_W-1:0]  wr_addr,
   input logic               irq_valid,
   input logic [ADDR_W-1:0]  irq_addr,
   input logic [ENTRIES-1:0] pend
);
   // R1
   reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !irq_valid);

   // R2
   irq_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_valid) |-> $past(wr_valid));

   // R2
   irq_addr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_valid) |-> (irq_addr == $past(wr_addr)));

   // R8
   irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |=> (!irq_valid || $past(wr_valid)));

   // R8
   slot_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |=> ($countones(pend) <= $countones($past(pend))));
endmodule

bind evict_hazard_watch evict_hazard_watch_chk #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_valid  (wr_valid),
   .wr_addr   (wr_addr),
   .irq_valid (irq_valid),
   .irq_addr  (irq_addr),
   .pend      (pend_vec)
);

// File: tb/sim_evict_hazard_watch.sv
`timescale 1ns/1ps
module sim_evict_hazard_watch;
   localparam int AW   = 26;
   localparam int NE   = 4;
   localparam int LIFE = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ev_valid = 1'b0, rd_valid = 1'b0, wr_valid = 1'b0;
   logic [AW-1:0] ev_addr = '0, rd_addr = '0, wr_addr = '0;
   logic          irq_valid;
   logic [AW-1:0] irq_addr;
   int            checks = 0;
   int            fails  = 0;

   always #2 clk = ~clk;

   evict_hazard_watch #(.ADDR_W(AW), .ENTRIES(NE), .LIFETIME(LIFE)) u0 (
      .clk(clk), .rst_n(rst_n),
      .ev_valid(ev_valid), .ev_addr(ev_addr),
      .rd_valid(rd_valid), .rd_addr(rd_addr),
      .wr_valid(wr_valid), .wr_addr(wr_addr),
      .irq_valid(irq_valid), .irq_addr(irq_addr)
   );

   typedef struct packed {
      logic        ev; logic [15:0] ea;
      logic        rd; logic [15:0] ra;
      logic        wr; logic [15:0] wa;
      logic        xv; logic [15:0] xa;
      logic [3:0]  req;
   } vec_t;

   localparam vec_t VEC [19] = '{
      '{1'b1,16'h10, 1'b0,16'h0,  1'b0,16'h0,  1'b0,16'h0,  4'd2}, // R2 evict
      '{1'b0,16'h0,  1'b1,16'h10, 1'b0,16'h0,  1'b0,16'h0,  4'd2}, // R2 read
      '{1'b0,16'h0,  1'b0,16'h0,  1'b1,16'h10, 1'b1,16'h10, 4'd2}, // R2 write fires
      '{1'b0,16'h0,  1'b0,16'h0,  1'b0,16'h0,  1'b0,16'h0,  4'd8}, // R8 pulse ends
      '{1'b0,16'h0,  1'b0,16'h0,  1'b1,16'h10, 1'b0,16'h0,  4'd8}, // R8 slot freed
      '{1'b1,16'h20, 1'b0,16'h0,  1'b0,16'h0,  1'b0,16'h0,  4'd3}, // R3 evict
      '{1'b0,16'h0,  1'b0,16'h0,  1'b1,16'h20, 1'b0,16'h0,  4'd3}, // R3 benign write
      '{1'b0,16'h0,  1'b1,16'h20, 1'b0,16'h0,  1'b0,16'h0,  4'd3}, // R3 read
      '{1'b0,16'h0,  1'b0,16'h0,  1'b1,16'h20, 1'b1,16'h20, 4'd3}, // R3 fires
      '{1'b0,16'h0,  1'b1,16'h30, 1'b1,16'h30, 1'b0,16'h0,  4'd4}, // R4 untracked
      '{1'b1,16'h40, 1'b0,16'h0,  1'b0,16'h0,  1'b0,16'h0,  4'd9}, // R9 evict
      '{1'b0,16'h0,  1'b1,16'h40, 1'b1,16'h40, 1'b0,16'h0,  4'd9}, // R9 read+write
      '{1'b0,16'h0,  1'b0,16'h0,  1'b1,16'h40, 1'b1,16'h40, 4'd9}, // R9 fires
      '{1'b1,16'h50, 1'b0,16'h0,  1'b0,16'h0,  1'b0,16'h0,  4'd6}, // R6 evict
      '{1'b0,16'h0,  1'b1,16'h50, 1'b0,16'h0,  1'b0,16'h0,  4'd6}, // R6 read
      '{1'b1,16'h50, 1'b0,16'h0,  1'b0,16'h0,  1'b0,16'h0,  4'd6}, // R6 re-evict
      '{1'b0,16'h0,  1'b0,16'h0,  1'b1,16'h50, 1'b0,16'h0,  4'd6}, // R6 write ignored
      '{1'b0,16'h0,  1'b1,16'h50, 1'b0,16'h0,  1'b0,16'h0,  4'd6}, // R6 read again
      '{1'b0,16'h0,  1'b0,16'h0,  1'b1,16'h50, 1'b1,16'h50, 4'd6}  // R6 fires
   };

   task automatic check(input logic xv, input logic [AW-1:0] xa, input int req, input string what);
      checks++;
      if ((irq_valid !== xv) || (xv && irq_addr !== xa)) begin
         fails++;
         $display("FAIL R%0d %s: actual irq=%b addr=%h expected irq=%b addr=%h",
                  req, what, irq_valid, irq_addr, xv, xa);
      end
   endtask

   task automatic step(input logic ev, input logic [AW-1:0] ea,
                       input logic rd, input logic [AW-1:0] ra,
                       input logic wr, input logic [AW-1:0] wa);
      ev_valid = ev; ev_addr = ea;
      rd_valid = rd; rd_addr = ra;
      wr_valid = wr; wr_addr = wa;
      @(posedge clk); #1;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) step(1'b0, '0, 1'b0, '0, 1'b0, '0);
   endtask

   task automatic do_reset();
      ev_valid = 1'b0; rd_valid = 1'b0; wr_valid = 1'b0;
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      do_reset();
      #1 check(1'b0, '0, 1, "reset state"); // R1

      for (int i = 0; i < 19; i++) begin
         step(VEC[i].ev, AW'(VEC[i].ea), VEC[i].rd, AW'(VEC[i].ra), VEC[i].wr, AW'(VEC[i].wa));
         check(VEC[i].xv, AW'(VEC[i].xa), int'(VEC[i].req), $sformatf("vector %0d", i));
      end

      // R1: a half-built pattern does not survive reset
      step(1'b1, AW'(16'h60), 1'b0, '0, 1'b0, '0);
      step(1'b0, '0, 1'b1, AW'(16'h60), 1'b0, '0);
      do_reset();
      step(1'b0, '0, 1'b0, '0, 1'b1, AW'(16'h60));
      check(1'b0, '0, 1, "pattern cleared by reset");

      // R5: read at edge L-1, write at edge L still flags
      step(1'b1, AW'(16'h70), 1'b0, '0, 1'b0, '0);
      idle(LIFE - 2);
      step(1'b0, '0, 1'b1, AW'(16'h70), 1'b0, '0);
      step(1'b0, '0, 1'b0, '0, 1'b1, AW'(16'h70));
      check(1'b1, AW'(16'h70), 5, "write at last edge");
      // R5: write one edge too late
      step(1'b1, AW'(16'h71), 1'b0, '0, 1'b0, '0);
      idle(LIFE - 2);
      step(1'b0, '0, 1'b1, AW'(16'h71), 1'b0, '0);
      idle(1);
      step(1'b0, '0, 1'b0, '0, 1'b1, AW'(16'h71));
      check(1'b0, '0, 5, "write after expiry");
      // R5: read at edge L is too late
      step(1'b1, AW'(16'h72), 1'b0, '0, 1'b0, '0);
      idle(LIFE - 1);
      step(1'b0, '0, 1'b1, AW'(16'h72), 1'b0, '0);
      step(1'b0, '0, 1'b0, '0, 1'b1, AW'(16'h72));
      check(1'b0, '0, 5, "read after expiry");

      // R7: full table replaces the oldest line
      do_reset();
      for (int j = 0; j < NE; j++) step(1'b1, AW'(16'h80 + j), 1'b0, '0, 1'b0, '0);
      step(1'b1, AW'(16'h90), 1'b0, '0, 1'b0, '0);
      step(1'b0, '0, 1'b1, AW'(16'h80), 1'b0, '0);
      step(1'b0, '0, 1'b0, '0, 1'b1, AW'(16'h80));
      check(1'b0, '0, 7, "oldest line displaced");
      step(1'b0, '0, 1'b1, AW'(16'h81), 1'b0, '0);
      step(1'b0, '0, 1'b0, '0, 1'b1, AW'(16'h81));
      check(1'b1, AW'(16'h81), 7, "second line kept");
      step(1'b0, '0, 1'b1, AW'(16'h90), 1'b0, '0);
      step(1'b0, '0, 1'b0, '0, 1'b1, AW'(16'h90));
      check(1'b1, AW'(16'h90), 7, "new line tracked");
      idle(1);
      check(1'b0, '0, 8, "quiet after pulse");

      finish_run();
   end
endmodule